// File: doc/BRIEF.md
# Clock Output Gating and Frequency-Select Controller

This block sits between the configuration registers of a system clock generator and its output pads. It receives the frequency-select straps that were latched at power-up, a seven-byte configuration image, a test-bypass request and the internally synthesized source clocks (processor, memory, bus, reference and 48 MHz). From these it produces a 5-bit code that picks the synthesizer's operating point, one gated copy of each clock output, a common pad enable, and a super-I/O clock running at either 48 MHz or 24 MHz.

The select code comes either from the straps or from register fields, depending on an override bit. Each output is enabled or disabled on its own. A disabled output is stopped cleanly and held low, because its enable is resampled only on a falling edge of its own source. A three-state bit drops the pad enable for board test. A bypass mode feeds the reference clock to every synthesized output in place of its usual source. The frequency synthesis itself is done elsewhere.

Top module: `clkgate_ctrl`

## Requirements
- R1: When byte 0 bit 3 is 1, `sel_code` becomes {byte 0 bit 2, byte 0 bits 7..4}, with byte 0 bit 2 as the MSB, one `clk` cycle after the inputs are applied.
- R2: When byte 0 bit 3 is 0, `sel_code` becomes {0, `strap_fs[3:0]`} one `clk` cycle later, so only codes 0 to 15 can be reached.
- R3: Each output follows its source while its enable bit is 1 and is driven low while the bit is 0. The enable bits are: processor outputs 2..0 at byte 1 bits 3..1; bus outputs 6..0 at byte 2 bits 6..0; memory outputs 7..0 at byte 3 bits 7..0; memory outputs 13..8 at byte 4 bits 5..0; 48 MHz output at byte 4 bit 6; super-I/O output at byte 4 bit 7; reference outputs 1..0 at byte 5 bits 1..0. Byte k occupies `cfg_reg[8k+7:8k]`.
- R4: `clk_oe` is 0 while byte 0 bit 0 is 1 and is 1 while that bit is 0, one `clk` cycle after the change.
- R5: While `bypass_req` is 1, every enabled processor, bus, memory, 48 MHz and super-I/O output toggles from `ref_src` in place of its own source.
- R6: Byte 1 bit 7 selects the super-I/O clock rate: 0 gives the 48 MHz source unchanged, 1 gives that source divided by two.
- R7: An enable change takes effect only while the affected clock is low. Every high pulse on a gated output therefore lasts a full source half-period.
- R8: Reserved bits have no effect on any output. These are byte 0 bit 1, byte 1 bits 6..4 and bit 0, byte 2 bit 7, byte 5 bits 7..2, and all of byte 6.
- R9: While `rst` is 1, all clock outputs are low, `clk_oe` is 0 and `sel_code` is 0.
- R10: The super-I/O rate switch happens only while both the 48 MHz source and the divided clock are low. Every high pulse is therefore exactly one 48 MHz half-period or one 24 MHz half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| strap_fs | input | 4 | Latched power-up frequency-select straps |
| cfg_reg | input | 56 | Seven configuration bytes, byte k at bits 8k+7..8k |
| bypass_req | input | 1 | Test-bypass request: reference clock drives all synthesized outputs |
| cpu_src | input | 1 | Processor source clock |
| sdr_src | input | 1 | Memory source clock |
| pci_src | input | 1 | Bus source clock |
| ref_src | input | 1 | Reference (crystal) clock |
| usb_src | input | 1 | 48 MHz source clock |
| cpu_clk | output | 3 | Gated processor clocks |
| pci_clk | output | 7 | Gated bus clocks |
| sdr_clk | output | 14 | Gated memory clocks |
| ref_clk | output | 2 | Gated reference clocks |
| usb_clk | output | 1 | Gated 48 MHz clock |
| sio_clk | output | 1 | Gated super-I/O clock, 48 or 24 MHz |
| clk_oe | output | 1 | Common pad output enable, low in three-state |
| sel_code | output | 5 | Active frequency-select code |

## Verification
A wrong enable register or a wrong gate flop shows at the ports as an output that is missing or present where it should not be. The scoreboard compares every output with its source at fine time steps within a few source periods of each change. A select mux that takes the wrong source, or a stale override bit, gives a wrong `sel_code` one control-clock cycle after the inputs are applied. A gate or rate switch that changes state in the wrong clock phase shows as a short high pulse, and the bench catches it by recording every pulse width while it toggles the enables and the rate at irregular times.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int N_CPU     = 3;
  localparam int N_PCI     = 7;
  localparam int N_SDR     = 14;
  localparam int N_REF     = 2;
  localparam int FS_W      = 4;
  localparam int SEL_W     = FS_W + 1;
  localparam int CFG_BYTES = 7;
  localparam int CFG_W     = CFG_BYTES * 8;
  localparam int N_GATED   = N_CPU + N_PCI + N_SDR + N_REF + 2;

  // bits that carry a function; everything else is reserved
  localparam logic [CFG_W-1:0] CFG_USED = 56'h00_03_FF_FF_7F_8E_FD;

  typedef struct packed {
    logic [N_CPU-1:0] cpu;
    logic [N_PCI-1:0] pci;
    logic [N_SDR-1:0] sdr;
    logic [N_REF-1:0] refc;
    logic             usb;
    logic             sio;
  } out_en_t;

  function automatic logic [7:0] cfg_byte(input logic [CFG_W-1:0] r, input int k);
    return r[8*k +: 8];
  endfunction
endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [FS_W-1:0]  strap_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             byp_i,
  output out_en_t          en_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             oe_o,
  output logic             sio24_o,
  output logic             byp_o
);
  logic [7:0] b0, b1, b2, b3, b4, b5;
  out_en_t    en_d;

  always_comb begin
    b0 = cfg_byte(cfg_i, 0);
    b1 = cfg_byte(cfg_i, 1);
    b2 = cfg_byte(cfg_i, 2);
    b3 = cfg_byte(cfg_i, 3);
    b4 = cfg_byte(cfg_i, 4);
    b5 = cfg_byte(cfg_i, 5);
    en_d.cpu  = b1[3:1];
    en_d.pci  = b2[N_PCI-1:0];
    en_d.sdr  = {b4[5:0], b3};
    en_d.usb  = b4[6];
    en_d.sio  = b4[7];
    en_d.refc = b5[N_REF-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= '0;
      sel_o   <= '0;
      oe_o    <= 1'b0;
      sio24_o <= 1'b0;
      byp_o   <= 1'b0;
    end else begin
      en_o    <= en_d;
      sel_o   <= b0[3] ? {b0[2], b0[7:4]} : {1'b0, strap_i};
      oe_o    <= ~b0[0];
      sio24_o <= b1[7];
      byp_o   <= byp_i;
    end
  end

  AST_SEL_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    cfg_i[3] |=> (sel_o[SEL_W-1] == $past(cfg_i[2]))); // R1
  AST_SEL_STRAP_MSB: assert property (@(posedge clk) disable iff (rst)
    !cfg_i[3] |=> (sel_o[SEL_W-1] == 1'b0)); // R2
  AST_TRISTATE_OE: assert property (@(posedge clk) disable iff (rst)
    cfg_i[0] |=> !oe_o); // R4
  AST_RESERVED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ((cfg_i & CFG_USED) == ($past(cfg_i) & CFG_USED)) &&
     (strap_i == $past(strap_i)) && (byp_i == $past(byp_i)))
    |=> ($stable(en_o) && $stable(sel_o) && $stable(oe_o) && $stable(sio24_o))); // R8
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic src_i,
  input  logic rst_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // enable is resampled while the source is low, so no partial pulse
  always_ff @(negedge src_i) begin
    if (rst_i) en_q <= 1'b0;
    else       en_q <= en_i;
  end

  assign clk_o = src_i & en_q;
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int N = 1
) (
  input  logic         src_i,
  input  logic         rst_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    clk_gate_cell u_cell (
      .src_i (src_i),
      .rst_i (rst_i),
      .en_i  (en_i[g]),
      .clk_o (clk_o[g])
    );
  end
endmodule

// File: rtl/sio_clk_sel.sv
module sio_clk_sel (
  input  logic src48_i,
  input  logic rst_i,
  input  logic sel24_i,
  input  logic en_i,
  output logic clk_o
);
  logic div_q;
  logic mode_q;
  logic en_q;

  always_ff @(posedge src48_i) begin
    if (rst_i) div_q <= 1'b0;
    else       div_q <= ~div_q;
  end

  // falling source edge with the divider low: both candidates are low
  always_ff @(negedge src48_i) begin
    if (rst_i) begin
      mode_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (!div_q) begin
      mode_q <= sel24_i;
      en_q   <= en_i;
    end
  end

  assign clk_o = (mode_q ? div_q : src48_i) & en_q;

  AST_SIO_SWITCH_LOW: assert property (@(posedge src48_i) disable iff (rst_i)
    (mode_q != $past(mode_q)) |-> !div_q); // R10
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [FS_W-1:0]  strap_fs,
  input  logic [CFG_W-1:0] cfg_reg,
  input  logic             bypass_req,
  input  logic             cpu_src,
  input  logic             sdr_src,
  input  logic             pci_src,
  input  logic             ref_src,
  input  logic             usb_src,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic [N_SDR-1:0] sdr_clk,
  output logic [N_REF-1:0] ref_clk,
  output logic             usb_clk,
  output logic             sio_clk,
  output logic             clk_oe,
  output logic [SEL_W-1:0] sel_code
);
  out_en_t en;
  logic    sio24;
  logic    byp;
  logic    cpu_eff, sdr_eff, pci_eff, usb_eff;

  ctrl_decode u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strap_i (strap_fs),
    .cfg_i   (cfg_reg),
    .byp_i   (bypass_req),
    .en_o    (en),
    .sel_o   (sel_code),
    .oe_o    (clk_oe),
    .sio24_o (sio24),
    .byp_o   (byp)
  );

  // test bypass: reference replaces every synthesized source
  assign cpu_eff = byp ? ref_src : cpu_src;
  assign sdr_eff = byp ? ref_src : sdr_src;
  assign pci_eff = byp ? ref_src : pci_src;
  assign usb_eff = byp ? ref_src : usb_src;

  clk_gate_bank #(.N(N_CPU)) u_cpu (
    .src_i (cpu_eff), .rst_i (rst), .en_i (en.cpu), .clk_o (cpu_clk));
  clk_gate_bank #(.N(N_PCI)) u_pci (
    .src_i (pci_eff), .rst_i (rst), .en_i (en.pci), .clk_o (pci_clk));
  clk_gate_bank #(.N(N_SDR)) u_sdr (
    .src_i (sdr_eff), .rst_i (rst), .en_i (en.sdr), .clk_o (sdr_clk));
  clk_gate_bank #(.N(N_REF)) u_ref (
    .src_i (ref_src), .rst_i (rst), .en_i (en.refc), .clk_o (ref_clk));
  clk_gate_bank #(.N(1)) u_usb (
    .src_i (usb_eff), .rst_i (rst), .en_i (en.usb), .clk_o (usb_clk));

  sio_clk_sel u_sio (
    .src48_i (usb_eff),
    .rst_i   (rst),
    .sel24_i (sio24),
    .en_i    (en.sio),
    .clk_o   (sio_clk)
  );
endmodule

// File: tb/tb_clkgate_ctrl.sv
`timescale 1ns/10ps
module tb_clkgate_ctrl;
  logic        clk = 1'b0, rst = 1'b1;
  logic [3:0]  strap_fs = '0;
  logic [55:0] cfg_reg = '0;
  logic        bypass_req = 1'b0;
  logic        cpu_src = 0, sdr_src = 0, pci_src = 0, ref_src = 0, usb_src = 0;
  logic [2:0]  cpu_clk;
  logic [6:0]  pci_clk;
  logic [13:0] sdr_clk;
  logic [1:0]  ref_clk;
  logic        usb_clk, sio_clk, clk_oe;
  logic [4:0]  sel_code;

  clkgate_ctrl dut (
    .clk(clk), .rst(rst), .strap_fs(strap_fs), .cfg_reg(cfg_reg),
    .bypass_req(bypass_req), .cpu_src(cpu_src), .sdr_src(sdr_src),
    .pci_src(pci_src), .ref_src(ref_src), .usb_src(usb_src),
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdr_clk(sdr_clk),
    .ref_clk(ref_clk), .usb_clk(usb_clk), .sio_clk(sio_clk),
    .clk_oe(clk_oe), .sel_code(sel_code));

  always #5  clk     = ~clk;
  always #4  cpu_src = ~cpu_src;
  always #5  sdr_src = ~sdr_src;
  always #15 pci_src = ~pci_src;
  always #35 ref_src = ~ref_src;
  always #10 usb_src = ~usb_src;

  typedef struct {
    logic [4:0]  sel;
    logic        oe, usb, sio, s24, byp;
    logic [2:0]  cpu;
    logic [6:0]  pci;
    logic [13:0] sdr;
    logic [1:0]  refc;
    string       seltag;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0, done_cnt = 0, issued = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // expected values from the requirement text
  function automatic exp_t make_exp(input logic [55:0] c, input logic [3:0] s, input logic b);
    exp_t e;
    e.sel    = c[3] ? {c[2], c[7:4]} : {1'b0, s};
    e.seltag = c[3] ? "R1" : "R2";
    e.oe     = !c[0];
    e.cpu    = c[11:9];
    e.pci    = c[22:16];
    e.sdr    = {c[37:32], c[31:24]};
    e.usb    = c[38];
    e.sio    = c[39];
    e.refc   = c[41:40];
    e.s24    = c[15];
    e.byp    = b;
    return e;
  endfunction

  task automatic drive(input logic [55:0] c, input logic [3:0] s, input logic b);
    @(negedge clk);
    cfg_reg = c; strap_fs = s; bypass_req = b;
    q.push_back(make_exp(c, s, b));
    issued++;
    wait (done_cnt == issued);
  endtask

  // monitor: pops each expected item and compares after settling
  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        exp_t e;
        int mc, mp, ms, mr, mu, sio_edges, expe, per;
        logic sio_prev, s_c, s_p, s_s, s_u;
        string t3;
        e = q[0];
        #300.25;
        check(sel_code == e.sel, e.seltag, "sel_code", sel_code, e.sel);
        check(clk_oe == e.oe, "R4", "clk_oe", clk_oe, e.oe);
        mc = 0; mp = 0; ms = 0; mr = 0; mu = 0; sio_edges = 0;
        sio_prev = sio_clk;
        for (int k = 0; k < 800; k++) begin
          s_c = e.byp ? ref_src : cpu_src;
          s_p = e.byp ? ref_src : pci_src;
          s_s = e.byp ? ref_src : sdr_src;
          s_u = e.byp ? ref_src : usb_src;
          for (int i = 0; i < 3; i++)  if (cpu_clk[i] !== (e.cpu[i] & s_c)) mc++;
          for (int i = 0; i < 7; i++)  if (pci_clk[i] !== (e.pci[i] & s_p)) mp++;
          for (int i = 0; i < 14; i++) if (sdr_clk[i] !== (e.sdr[i] & s_s)) ms++;
          for (int i = 0; i < 2; i++)  if (ref_clk[i] !== (e.refc[i] & ref_src)) mr++;
          if (usb_clk !== (e.usb & s_u)) mu++;
          if (sio_clk && !sio_prev) sio_edges++;
          sio_prev = sio_clk;
          #0.5;
        end
        t3 = e.byp ? "R5" : "R3";
        check(mc == 0, t3, "cpu_clk mismatches", mc, 0);
        check(mp == 0, t3, "pci_clk mismatches", mp, 0);
        check(ms == 0, t3, "sdr_clk mismatches", ms, 0);
        check(mr == 0, "R3", "ref_clk mismatches", mr, 0);
        check(mu == 0, t3, "usb_clk mismatches", mu, 0);
        per  = e.byp ? 70 : 20;
        expe = !e.sio ? 0 : (e.s24 ? 400 / (2 * per) : 400 / per);
        check((sio_edges >= expe - 1) && (sio_edges <= expe + 1), "R6",
              "sio_clk rising edges", sio_edges, expe);
        void'(q.pop_front());
        done_cnt++;
      end
    end
  end

  // pulse-width recorder for the gating-phase checks
  bit rec = 0;
  int cpu_run = 0, sio_run = 0, cpu_bad = 0, sio_bad = 0, cpu_pulses = 0, sio_pulses = 0;
  initial begin
    #0.25;
    forever begin
      if (rec) begin
        if (cpu_clk[0]) cpu_run++;
        else if (cpu_run != 0) begin
          cpu_pulses++;
          if (cpu_run != 8) cpu_bad++;
          cpu_run = 0;
        end
        if (sio_clk) sio_run++;
        else if (sio_run != 0) begin
          sio_pulses++;
          if (sio_run != 20 && sio_run != 40) sio_bad++;
          sio_run = 0;
        end
      end
      #0.5;
    end
  end

  localparam logic [55:0] CFG_DEF = {8'h00, 8'h03, 8'hFF, 8'hFF, 8'h7F, 8'h0E, 8'h00};

  initial begin
    // R9: reset state
    #200.25;
    begin
      int hi = 0;
      for (int k = 0; k < 200; k++) begin
        if (|{cpu_clk, pci_clk, sdr_clk, ref_clk, usb_clk, sio_clk}) hi++;
        #0.5;
      end
      check(hi == 0, "R9", "clock high samples in reset", hi, 0);
    end
    check(clk_oe == 1'b0, "R9", "clk_oe in reset", clk_oe, 0);
    check(sel_code == 5'd0, "R9", "sel_code in reset", sel_code, 0);
    @(negedge clk); rst = 1'b0;

    // R2 strap select, all enabled, 48 MHz super-I/O
    drive(CFG_DEF, 4'b1011, 1'b0);
    // R1 override plus mixed enables and 24 MHz super-I/O (R6)
    drive({8'h00, 8'h01, 8'h3C, 8'h0F, 8'h55, 8'h8A, 8'hAC}, 4'b0110, 1'b0);
    // R4 three-state
    drive(CFG_DEF | 56'h1, 4'b0001, 1'b0);
    // R8 reserved bits set: same outputs as default
    drive({8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h7F, 8'h02}, 4'b1011, 1'b0);
    // R5 bypass from reference
    drive(CFG_DEF, 4'b0110, 1'b1);
    // R3 everything disabled, override to code 15
    drive({8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF8}, 4'b0000, 1'b0);

    // R7 and R10: toggle enables and rate at irregular times
    drive(CFG_DEF, 4'b0000, 1'b0);
    rec = 1;
    for (int n = 0; n < 24; n++) begin
      #(7 + (n * 13) % 23);
      cfg_reg[9]  = ~cfg_reg[9];
      #(5 + (n * 7) % 17);
      cfg_reg[15] = ~cfg_reg[15];
    end
    #200;
    rec = 0;
    check(cpu_bad == 0, "R7", "short cpu_clk pulses", cpu_bad, 0);
    check(cpu_pulses > 0, "R7", "cpu_clk pulses seen", cpu_pulses, 1);
    check(sio_bad == 0, "R10", "sio_clk pulses of wrong width", sio_bad, 0);
    check(sio_pulses > 0, "R10", "sio_clk pulses seen", sio_pulses, 1);
    summary();
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, issued);
    summary();
  end
endmodule